// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

The block turns host data words into asynchronous serial frames on a single output line. A host writes a word into a one-entry holding buffer. When transmission is enabled and the shifter is free, the word moves into the shifter, the buffer frees up, and the frame goes out bit by bit. A frame has one low start bit, then 7, 8 or 9 data bits sent least significant bit first, then an optional odd or even parity bit, then one or two high stop bits. A word written while a frame is in flight waits in the buffer. It follows the current frame with no idle time between them.

Each bit lasts 16×(n+1) ticks of a selected source clock. The source is the core clock, or the core clock divided by 8 or by 32 by a prescaler that runs freely from reset. The value n is the programmable divisor. The host chooses when a one-cycle interrupt pulse fires: either when the buffer hands its word to the shifter, or when the last stop bit of a frame has finished.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, txd_o is 1, buf_empty_o is 1 and irq_o is 0.
- R2: The line idles at 1. A frame starts with one bit at 0, data bits follow least significant bit first, and the frame ends with stop bits at 1.
- R3: char_len_i selects the number of data bits: 2'b00 gives 7, 2'b01 gives 8, 2'b10 gives 9 and 2'b11 gives 8. Data bits above the selected length are not sent.
- R4: par_mode_i 2'b01 adds an odd parity bit and 2'b10 adds an even parity bit, both sent right after the last data bit. 2'b00 and 2'b11 add no parity bit. Parity is computed over the data bits that are sent.
- R5: stop2_i=0 sends one stop bit and stop2_i=1 sends two.
- R6: Each bit lasts 16×(div_i+1) source ticks. src_sel_i 2'b00 ticks every cycle. 2'b01 ticks when the low 3 bits of a 5-bit counter, free-running since reset, are all ones. 2'b10 and 2'b11 tick when all 5 bits of that counter are ones.
- R7: A word moves to the shifter only at a clock edge where tx_en_i is 1 and the buffer is full. While tx_en_i is 0, a buffered word stays held and the line stays at 1.
- R8: buf_empty_o drops to 0 the cycle after a write and returns to 1 the cycle after the word moves to the shifter. A write in the same cycle as a hand-off leaves the new word buffered. A write into a full buffer replaces the held word.
- R9: With irq_sel_i=0, irq_o pulses high for one cycle, starting the cycle after each hand-off to the shifter.
- R10: With irq_sel_i=1, irq_o pulses high for one cycle, starting the cycle after the last stop bit of a frame ends.
- R11: A word held while a frame is in flight is loaded at the edge where the last stop bit ends. Its start bit follows immediately, with no idle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 2 | Bit-rate source select |
| div_i | input | 8 | Bit-rate divisor n |
| char_len_i | input | 2 | Data-bit count select |
| par_mode_i | input | 2 | Parity select |
| stop2_i | input | 1 | Two stop bits when 1 |
| irq_sel_i | input | 1 | Interrupt timing select |
| tx_en_i | input | 1 | Transmit enable |
| wr_i | input | 1 | Buffer write strobe |
| wdata_i | input | 9 | Word to transmit |
| buf_empty_o | output | 1 | Holding buffer is empty |
| txd_o | output | 1 | Serial output |
| irq_o | output | 1 | Interrupt pulse |

## Verification
Three events can land on the same clock edge: the host writes a new word, the held word moves into the shifter, and the previous frame's last stop bit ends. The bench provokes this in two ways. In one, it raises the enable in the very cycle it writes a second word. In the other, it queues a word behind a running frame, so the frame end and the reload coincide. A behavioural model built from bit queues predicts txd_o, buf_empty_o and irq_o every cycle. The model must agree that the buffer stays full with the new word, that the line shows no idle bit, and that exactly one interrupt pulse appears, chosen by irq_sel_i.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_MID   = 2'b01,
    LEN_FULL  = 2'b10,
    LEN_MID_X = 2'b11
  } char_len_e;

  typedef enum logic [1:0] {
    PAR_NONE   = 2'b00,
    PAR_ODD    = 2'b01,
    PAR_EVEN   = 2'b10,
    PAR_NONE_X = 2'b11
  } par_mode_e;

  typedef enum logic [1:0] {
    SRC_DIV1  = 2'b00,
    SRC_DIV8  = 2'b01,
    SRC_DIV32 = 2'b10,
    SRC_DIV32X = 2'b11
  } src_sel_e;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
  import uart_tx_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_W   = 5,
  parameter int MID_W   = 3,
  parameter int OVERSMP = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       src_sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             restart_i,
  output logic             bit_tick_o
);
  localparam int PH_W = $clog2(OVERSMP);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] sub_q;
  logic [PH_W-1:0]  ph_q;
  logic             src_tick;
  src_sel_e         sel;

  assign sel = src_sel_e'(src_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  always_comb begin
    unique case (sel)
      SRC_DIV1: src_tick = 1'b1;
      SRC_DIV8: src_tick = &pre_q[MID_W-1:0];
      default:  src_tick = &pre_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      ph_q  <= '0;
    end else if (restart_i) begin
      sub_q <= '0;
      ph_q  <= '0;
    end else if (run_i && src_tick) begin
      if (sub_q >= div_i) begin
        sub_q <= '0;
        ph_q  <= ph_q + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign bit_tick_o = run_i && src_tick && (sub_q >= div_i) && (ph_q == PH_W'(OVERSMP-1));
endmodule

// File: rtl/uart_tx_buf.sv
module uart_tx_buf #(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (wr_i) begin
      // a write wins over a same-cycle take
      full_o <= 1'b1;
      data_o <= wdata_i;
    end else if (take_i) begin
      full_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              stop2_i,
  input  logic              bit_tick_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              txd_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame, sh_q;
  logic [CNT_W-1:0]   left_q;
  logic [DATA_W-1:0]  mask;
  logic               busy_q;
  logic               par_en, par_bit;
  int                 len, nbits;
  char_len_e          clen;
  par_mode_e          pmode;

  assign clen  = char_len_e'(char_len_i);
  assign pmode = par_mode_e'(par_mode_i);

  always_comb begin
    unique case (clen)
      LEN_SHORT: len = DATA_W - 2;
      LEN_FULL:  len = DATA_W;
      default:   len = DATA_W - 1;
    endcase
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < len);
  end

  assign par_en  = (pmode == PAR_ODD) || (pmode == PAR_EVEN);
  assign par_bit = (pmode == PAR_ODD) ? ~^(data_i & mask) : ^(data_i & mask);

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < len) frame[1+i] = data_i[i];
    end
    if (par_en) frame[1+len] = par_bit;
  end

  assign nbits = 1 + len + (par_en ? 1 : 0) + (stop2_i ? 2 : 1);

  assign done_o = busy_q && bit_tick_i && (left_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sh_q   <= frame;
      left_q <= CNT_W'(nbits - 1);
    end else if (done_o) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
    end else if (busy_q && bit_tick_i) begin
      sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        src_sel_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [1:0]        char_len_i,
  input  logic [1:0]        par_mode_i,
  input  logic              stop2_i,
  input  logic              irq_sel_i,
  input  logic              tx_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              buf_empty_o,
  output logic              txd_o,
  output logic              irq_o
);
  logic              buf_full;
  logic [DATA_W-1:0] buf_data;
  logic              busy, done, load, bit_tick;
  logic              irq_q;

  assign load = tx_en_i && buf_full && (!busy || done);

  uart_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .wr_i, .wdata_i,
    .take_i (load),
    .full_o (buf_full),
    .data_o (buf_data)
  );

  uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i, .rst_ni, .src_sel_i, .div_i,
    .run_i      (busy),
    .restart_i  (load),
    .bit_tick_o (bit_tick)
  );

  uart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i     (load),
    .data_i     (buf_data),
    .char_len_i, .par_mode_i, .stop2_i,
    .bit_tick_i (bit_tick),
    .busy_o     (busy),
    .done_o     (done),
    .txd_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_sel_i ? done : load;
  end

  assign irq_o       = irq_q;
  assign buf_empty_o = ~buf_full;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic wr_i,
  input logic irq_sel_i,
  input logic busy_i,
  input logic txd_i,
  input logic buf_empty_i,
  input logic irq_i
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> txd_i); // R2
  AST_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !txd_i); // R2
  AST_NO_START_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(tx_en_i)); // R7
  AST_EMPTY_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (buf_empty_i || $past(wr_i))); // R8
  AST_IRQ_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && !$past(irq_sel_i)) |-> irq_i); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R10
endmodule

bind uart_tx_core uart_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .wr_i        (wr_i),
  .irq_sel_i   (irq_sel_i),
  .busy_i      (busy),
  .txd_i       (txd_o),
  .buf_empty_i (buf_empty_o),
  .irq_i       (irq_o)
);

// File: tb/uart_tx_core_tb.sv
module uart_tx_core_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [7:0] div = 8'd0;
  logic [1:0] char_len = 2'b01;
  logic [1:0] par_mode = 2'b00;
  logic       stop2 = 1'b0;
  logic       irq_sel = 1'b0;
  logic       tx_en = 1'b0;
  logic       wr = 1'b0;
  logic [8:0] wdata = '0;
  logic       buf_empty, txd, irq;

  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  always #2 clk = ~clk;

  uart_tx_core u_dut (
    .clk_i(clk), .rst_ni, .src_sel_i(src_sel), .div_i(div),
    .char_len_i(char_len), .par_mode_i(par_mode), .stop2_i(stop2),
    .irq_sel_i(irq_sel), .tx_en_i(tx_en), .wr_i(wr), .wdata_i(wdata),
    .buf_empty_o(buf_empty), .txd_o(txd), .irq_o(irq)
  );

  // behavioural reference
  int      m_pre, m_sub, m_ph;
  bit      m_busy, m_full, m_txd, m_irq;
  bit [8:0] m_data;
  bit      m_q[$];

  function automatic int len_of(logic [1:0] c);
    return (c == 2'b00) ? 7 : (c == 2'b10) ? 9 : 8;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_sub = 0; m_ph = 0;
      m_busy = 0; m_full = 0; m_txd = 1; m_irq = 0; m_data = '0;
      m_q.delete();
    end else begin
      bit tick, done, ld;
      tick = (src_sel == 2'b00) || (src_sel == 2'b01 && (m_pre % 8) == 7) ||
             (src_sel[1] && m_pre == 31);
      done = 0;
      if (m_busy && tick) begin
        if (m_sub >= int'(div)) begin
          m_sub = 0;
          if (m_ph == 15) begin
            m_ph = 0;
            void'(m_q.pop_front());
            if (m_q.size() == 0) done = 1;
          end else m_ph++;
        end else m_sub++;
      end
      ld = tx_en && m_full && (!m_busy || done);
      if (done && !ld) m_busy = 0;
      if (ld) begin
        int l, ones;
        l = len_of(char_len); ones = 0;
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < l; i++) begin
          m_q.push_back(m_data[i]);
          ones += m_data[i];
        end
        if (par_mode == 2'b01) m_q.push_back(((ones % 2) == 0));
        if (par_mode == 2'b10) m_q.push_back(((ones % 2) == 1));
        m_q.push_back(1'b1);
        if (stop2) m_q.push_back(1'b1);
        m_busy = 1; m_sub = 0; m_ph = 0; m_full = 0;
      end
      if (wr) begin m_full = 1; m_data = wdata; end
      m_irq = irq_sel ? done : ld;
      m_pre = (m_pre + 1) % 32;
      m_txd = m_busy ? m_q[0] : 1'b1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      check(cur_req, "txd_o", int'(txd), int'(m_txd));
      check(cur_req, "buf_empty_o", int'(buf_empty), int'(!m_full));
      check(cur_req, "irq_o", int'(irq), int'(m_irq));
    end
  end

  task automatic put(logic [8:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && (m_busy || m_full); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset txd_o", int'(txd), 1);
    check("R1", "reset buf_empty_o", int'(buf_empty), 1);
    check("R1", "reset irq_o", int'(irq), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    cur_req = "R2"; tx_en = 1'b1;
    put(9'h0A5); drain();
    cur_req = "R3"; char_len = 2'b00; put(9'h1FF); drain();
    char_len = 2'b10; put(9'h155); drain();
    char_len = 2'b11; put(9'h13C); drain();
    cur_req = "R4"; char_len = 2'b01; par_mode = 2'b01; put(9'h0B3); drain();
    par_mode = 2'b10; put(9'h0B3); drain();
    par_mode = 2'b11; put(9'h071); drain();
    cur_req = "R5"; par_mode = 2'b00; stop2 = 1'b1; put(9'h0F0); drain();
    cur_req = "R6"; stop2 = 1'b0; div = 8'd2; src_sel = 2'b01; put(9'h066); drain();
    div = 8'd0; src_sel = 2'b10; put(9'h099); drain();
    src_sel = 2'b00; div = 8'd1;

    cur_req = "R7"; tx_en = 1'b0; put(9'h0C3);
    repeat (100) @(negedge clk);
    check("R7", "held buf_empty_o", int'(buf_empty), 0);
    check("R7", "held txd_o", int'(txd), 1);
    tx_en = 1'b1; drain();

    cur_req = "R8"; tx_en = 1'b0; put(9'h011); put(9'h022);
    @(negedge clk); tx_en = 1'b1; wr = 1'b1; wdata = 9'h033;
    @(negedge clk); wr = 1'b0;
    check("R8", "buffer kept full", int'(buf_empty), 0);
    drain();

    cur_req = "R9"; irq_sel = 1'b0; put(9'h05A); drain();
    cur_req = "R10"; irq_sel = 1'b1; put(9'h0A5); drain();

    cur_req = "R11"; put(9'h001); repeat (20) @(negedge clk);
    put(9'h0FE); put(9'h0AA); drain();
    irq_sel = 1'b0; put(9'h101); repeat (5) @(negedge clk); put(9'h080); drain();

    finish_run();
  end
endmodule